// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block is the periodic-event source of a real-time clock. It takes a one-cycle enable that pulses at 32.768 kHz and divides it by a power of two. A 4-bit rate code from the first control register selects the divisor. The result is a one-cycle event strobe that feeds the interrupt-flag logic.

Two conditions gate the generator. The oscillator must be running, which the upper two bits of the 3-bit divider-control field signal. The periodic-enable bit of the second control register must also be set. Whenever the generator is gated off, or its rate or divider field changes, the internal tick counter restarts from zero. A fresh start therefore always yields a full period.

Top module: `periodic_rate_gen`

## Requirements
- R1: With rate code 0, `per_evt` never asserts.
- R2: Rate code 1 gives a period of 128 ticks and rate code 2 a period of 256 ticks, the same as codes 8 and 9.
- R3: For a rate code n from 3 to 15, `per_evt` fires once every 2^(n-1) ticks. That is 4 ticks at code 3, 8 ticks at code 4, and 16384 ticks at code 15.
- R4: When `div_ctl[2]` and `div_ctl[1]` are both 0 (oscillator stopped), `per_evt` never asserts. Any other value of those two bits lets the generator run.
- R5: While `per_en` is 0, `per_evt` never asserts and the count is discarded.
- R6: After `per_en` rises with a non-zero rate code, the first event comes after one full period of ticks at the current rate.
- R7: Any change of `rate_sel` or `div_ctl` restarts the count. The next event then comes a full period of ticks after the change, and no event is issued in the cycle after the change.
- R8: `per_evt` is high for exactly one clock cycle. It is asserted in the cycle after the clock edge that samples the tick completing the period.
- R9: After reset, `per_evt` is 0 and the count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 32.768 kHz time-base enable |
| rate_sel | input | 4 | Periodic rate code |
| div_ctl | input | 3 | Divider-chain control field |
| per_en | input | 1 | Periodic-event enable |
| per_evt | output | 1 | One-cycle periodic event strobe |

## Verification
The strobe is registered. A tick driven for one cycle therefore produces its event in the very next cycle, and the bench samples `per_evt` at the falling edge that ends the tick cycle. It then samples once more a cycle later to confirm the pulse has dropped. Configuration changes are applied one full cycle before any tick, so the restart of the count is settled before it is measured. The bench's expected tick count is reset on every change of configuration and on every cycle spent gated off.

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
  parameter int RATE_W = 4,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [DIV_W-1:0]  div_ctl,
  input  logic              per_en,
  output logic              per_evt
);
  localparam int CNT_W = (1 << RATE_W) - 2;

  logic [RATE_W-1:0] eff_code, rate_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  cnt, last;
  logic              osc_on, run, cfg_chg;

  assign eff_code = (rate_sel == RATE_W'(1)) ? RATE_W'(8) :
                    (rate_sel == RATE_W'(2)) ? RATE_W'(9) : rate_sel;
  assign osc_on   = |div_ctl[DIV_W-1:DIV_W-2];
  assign run      = per_en && osc_on && (rate_sel != '0);
  assign cfg_chg  = (rate_sel != rate_q) || (div_ctl != div_q);

  always_comb begin
    for (int i = 0; i < CNT_W; i++)
      last[i] = (i < (int'(eff_code) - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      per_evt <= 1'b0;
      rate_q  <= '0;
      div_q   <= '0;
    end else begin
      rate_q  <= rate_sel;
      div_q   <= div_ctl;
      per_evt <= 1'b0;
      if (!run || cfg_chg)
        cnt <= '0;
      else if (tick) begin
        if (cnt == last) begin
          cnt     <= '0;
          per_evt <= 1'b1;
        end else
          cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/periodic_rate_gen_chk.sv
module periodic_rate_gen_chk #(
  parameter int RATE_W = 4,
  parameter int DIV_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [RATE_W-1:0] rate_sel,
  input logic [DIV_W-1:0]  div_ctl,
  input logic              per_en,
  input logic              per_evt
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |=> !per_evt);  // R8
  AST_EVT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |-> $past(tick));  // R8
  AST_EVT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |-> $past(per_en));  // R5
  AST_EVT_NEEDS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |-> ($past(rate_sel) != '0));  // R1
  AST_EVT_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |-> ($past(div_ctl[DIV_W-1:DIV_W-2]) != 2'b00));  // R4
  AST_QUIET_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_sel) |=> !per_evt);  // R7
endmodule

bind periodic_rate_gen periodic_rate_gen_chk #(.RATE_W(RATE_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rate_sel(rate_sel),
  .div_ctl(div_ctl), .per_en(per_en), .per_evt(per_evt)
);

// File: tb/tb_periodic_rate_gen.sv
module tb_periodic_rate_gen;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, per_en = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic [2:0] div_ctl = 3'd2;
  logic       per_evt;

  int checks = 0, fails = 0, cnt_m = 0;
  bit done = 1'b0;

  periodic_rate_gen dut (.clk(clk), .rst_n(rst_n), .tick(tick), .rate_sel(rate_sel),
    .div_ctl(div_ctl), .per_en(per_en), .per_evt(per_evt));

  always #(CLK_P/2) clk = ~clk;

  function automatic int period_of(input logic [3:0] r);
    if (r == 4'd0) return 0;
    if (r == 4'd1) return 128;
    if (r == 4'd2) return 256;
    return 1 << (r - 1);
  endfunction

  function automatic bit active(input logic [3:0] r, input logic [2:0] d, input logic e);
    return (r != 4'd0) && (d[2:1] != 2'b00) && e;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s per_evt=%0b expected=%0b (rate=%0d div=%0d en=%0b)",
               req, act, exp, rate_sel, div_ctl, per_en);
    end
  endtask

  task automatic set_cfg(input logic [3:0] r, input logic [2:0] d, input logic e);
    @(negedge clk);
    rate_sel = r; div_ctl = d; per_en = e;
    cnt_m = 0;
    @(negedge clk);
    check("R7", per_evt, 1'b0);
  endtask

  task automatic do_tick(input string req);
    logic exp;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    exp = 1'b0;
    if (active(rate_sel, div_ctl, per_en)) begin
      cnt_m++;
      if (cnt_m == period_of(rate_sel)) begin exp = 1'b1; cnt_m = 0; end
    end else cnt_m = 0;
    check(req, per_evt, exp);
    @(negedge clk);
    check("R8", per_evt, 1'b0);
  endtask

  task automatic run_ticks(input int n, input string req);
    for (int i = 0; i < n; i++) do_tick(req);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 190000) begin @(posedge clk); wd++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240511));
    repeat (3) @(negedge clk);
    check("R9", per_evt, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", per_evt, 1'b0);

    set_cfg(4'd3, 3'd2, 1'b1);  run_ticks(12, "R3");
    set_cfg(4'd4, 3'd2, 1'b1);  run_ticks(17, "R3");
    set_cfg(4'd0, 3'd2, 1'b1);  run_ticks(40, "R1");
    set_cfg(4'd1, 3'd2, 1'b1);  run_ticks(130, "R2");
    set_cfg(4'd2, 3'd4, 1'b1);  run_ticks(260, "R2");
    set_cfg(4'd3, 3'd0, 1'b1);  run_ticks(10, "R4");
    set_cfg(4'd3, 3'd1, 1'b1);  run_ticks(10, "R4");
    set_cfg(4'd3, 3'd6, 1'b1);  run_ticks(9, "R4");

    set_cfg(4'd4, 3'd2, 1'b1);  run_ticks(5, "R6");
    set_cfg(4'd4, 3'd2, 1'b0);  run_ticks(10, "R5");
    set_cfg(4'd4, 3'd2, 1'b1);  run_ticks(9, "R6");

    set_cfg(4'd5, 3'd2, 1'b1);  run_ticks(10, "R7");
    set_cfg(4'd6, 3'd2, 1'b1);  run_ticks(33, "R7");
    set_cfg(4'd6, 3'd3, 1'b1);  run_ticks(33, "R7");

    set_cfg(4'd15, 3'd2, 1'b1); run_ticks(16385, "R3");

    for (int k = 0; k < 30; k++) begin
      logic [3:0] r;
      logic [2:0] d;
      logic e;
      r = 4'($urandom_range(0, 7));
      d = 3'($urandom_range(0, 7));
      e = ($urandom_range(0, 3) != 0);
      set_cfg(r, d, e);
      run_ticks($urandom_range(5, 90), active(r, d, e) ? "R3" : "R5");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule